// File: doc/BRIEF.md
# Credit-Aware Priority Round-Robin Transmit Scheduler

This block decides which of several protocol units may next move a packet into a shared pool of outbound physical-layer buffers. Every requester presents a valid flag, a 2-bit priority and a packet length. The block keeps a running count of occupied buffers. It grants credit to each priority level only while enough free buffers remain above a programmable watermark for that level. A requester whose priority has no credit takes no part in arbitration.

Among the requesters that hold credit, the highest priority always wins. Requesters that share that top priority are served round-robin, one whole packet at a time. A grant lasts until the last beat of the packet is accepted, so a packet is never preempted part way through. Each grant claims one buffer, and a release pulse from the physical layer returns one buffer. The depth of the pool follows the port mode: four narrow ports, two medium ports, or a single wide port.

Top module: `tx_credit_arb`

## Requirements
- R1: After reset no grant is driven (`gnt_o` = 0), `occ_o` is 0 and the round-robin search starts at requester 0.
- R2: The pool depth is 8 when `mode_i` = 0, 16 when `mode_i` = 1, and 32 when `mode_i` is 2 or 3.
- R3: Priority p holds credit exactly when `occ_o` + watermark[p] < depth. Watermark p sits in `wm_i[6p+5:6p]`. Repeated grants at one priority therefore stop once `occ_o` reaches max(0, depth - watermark).
- R4: A valid requester whose priority has no credit is never granted, even when its priority is the highest present. Credited requesters at lower priority are granted instead.
- R5: Of the credited valid requesters, one with the numerically largest priority is granted. Requester i's priority is `req_pri_i[2i+1:2i]`.
- R6: Among credited requesters at the top priority, the search starts at the requester after the one whose packet last completed and wraps from NREQ-1 to 0.
- R7: A grant to requester i drives `gnt_o` one-hot at bit i and `gnt_idx_o` = i. It lasts for len+1 accepted beats, where len = `req_len_i[4i+3:4i]` and a beat is accepted in any cycle with `beat_rdy_i` high. `beat_last_o` is high only in the cycle of the final accepted beat. A higher-priority arrival does not change an active grant.
- R8: `occ_o` rises by 1 on each new grant and falls by 1 on each `rel_i` pulse. When both happen in the same cycle, it stays unchanged.
- R9: A grant decided at a clock edge is visible right after that edge. After a packet completes, `gnt_o` is 0 for exactly one cycle before the next grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Port mode selecting pool depth |
| wm_i | input | 24 | Four 6-bit per-priority free-buffer watermarks |
| req_vld_i | input | 4 | Requester has a packet pending |
| req_pri_i | input | 8 | Four 2-bit requester priorities |
| req_len_i | input | 16 | Four 4-bit lengths, beats minus one |
| beat_rdy_i | input | 1 | Downstream accepts a beat this cycle |
| rel_i | input | 1 | One physical buffer freed |
| gnt_o | output | 4 | One-hot active grant |
| gnt_idx_o | output | 2 | Index of granted requester |
| beat_last_o | output | 1 | Final beat of the granted packet accepted |
| occ_o | output | 6 | Occupied buffer count |

## Verification
The assertions assume two things about the inputs. A release pulse never arrives while the occupied count is zero. The port mode changes only while the pool is empty, so the count never exceeds the current depth. The stimulus keeps to both rules. It changes the mode only after every granted buffer has been released, and it issues exactly as many release pulses as it counted grants. Requesters keep their priority and length steady while they are granted, and the sweeps hold the watermarks constant within each run.

// File: rtl/txa_pkg.sv
package txa_pkg;
  localparam int PRI_W = 2;
  localparam int NPRI  = 1 << PRI_W;

  typedef enum logic [1:0] {
    MODE_QUAD_NARROW = 2'd0,
    MODE_DUAL_MEDIUM = 2'd1,
    MODE_SINGLE_WIDE = 2'd2,
    MODE_SPARE       = 2'd3
  } port_mode_e;

  // Left shift applied to the base depth for a given port mode
  function automatic int unsigned depth_shift(input logic [1:0] mode);
    case (port_mode_e'(mode))
      MODE_QUAD_NARROW: return 0;
      MODE_DUAL_MEDIUM: return 1;
      default:          return 2;
    endcase
  endfunction
endpackage

// File: rtl/txa_credit.sv
module txa_credit
  import txa_pkg::*;
#(
  parameter int BASE_DEPTH = 8,
  parameter int WM_W       = 6,
  parameter int CNT_W      = 6
) (
  input  logic [1:0]           mode_i,
  input  logic [NPRI*WM_W-1:0] wm_i,
  input  logic [CNT_W-1:0]     occ_i,
  output logic [CNT_W-1:0]     depth_o,
  output logic [NPRI-1:0]      credit_o
);
  localparam int SUM_W = ((WM_W > CNT_W) ? WM_W : CNT_W) + 1;

  always_comb begin
    depth_o = CNT_W'(BASE_DEPTH) << depth_shift(mode_i);
  end

  // A level keeps credit while occupancy plus its reserve stays below depth
  for (genvar p = 0; p < NPRI; p++) begin : g_lvl
    logic [SUM_W-1:0] need;
    assign need        = SUM_W'(occ_i) + SUM_W'(wm_i[p*WM_W +: WM_W]);
    assign credit_o[p] = need < SUM_W'(depth_o);
  end
endmodule

// File: rtl/txa_picker.sv
module txa_picker
  import txa_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NREQ-1:0]       elig_i,
  input  logic [NREQ*PRI_W-1:0] pri_i,
  input  logic [IDX_W-1:0]      ptr_i,
  output logic                  pick_vld_o,
  output logic [IDX_W-1:0]      pick_idx_o
);
  logic [PRI_W-1:0] pri_a [NREQ];
  logic [PRI_W-1:0] top_pri;
  logic             any_elig;
  logic [NREQ-1:0]  cand;
  logic             hi_waiting;

  for (genvar i = 0; i < NREQ; i++) begin : g_unpack
    assign pri_a[i] = pri_i[i*PRI_W +: PRI_W];
    assign cand[i]  = elig_i[i] && (pri_a[i] == top_pri);
  end

  // Highest priority among eligible requesters
  always_comb begin
    top_pri  = '0;
    any_elig = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (elig_i[i] && (!any_elig || pri_a[i] > top_pri)) begin
        top_pri  = pri_a[i];
        any_elig = 1'b1;
      end
    end
  end

  // Rotating search over the top-priority candidates, starting at ptr
  always_comb begin
    pick_vld_o = 1'b0;
    pick_idx_o = '0;
    for (int k = 0; k < NREQ; k++) begin
      int j;
      j = (int'(ptr_i) + k) % NREQ;
      if (!pick_vld_o && cand[IDX_W'(j)]) begin
        pick_vld_o = 1'b1;
        pick_idx_o = IDX_W'(j);
      end
    end
  end

  always_comb begin
    hi_waiting = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (elig_i[i] && pri_a[i] > pri_a[pick_idx_o]) hi_waiting = 1'b1;
    end
  end

  AST_PICK_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld_o |-> elig_i[pick_idx_o]); // R4
  AST_PICK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld_o |-> !hi_waiting); // R5
  AST_PICK_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_i) |-> pick_vld_o); // R5
endmodule

// File: rtl/txa_occupancy.sv
module txa_occupancy #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] occ_o
);
  logic [CNT_W-1:0] occ_q, occ_d;
  logic             occ_en;

  always_comb begin
    occ_en = inc_i ^ dec_i;
    occ_d  = occ_q;
    if (inc_i && !dec_i)                    occ_d = occ_q + 1'b1;
    else if (dec_i && !inc_i && occ_q != 0) occ_d = occ_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign occ_o = occ_q;

  AST_OCC_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !dec_i) |=> occ_q == $past(occ_q) + CNT_W'(1)); // R8
  AST_OCC_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i) |=> occ_q == $past(occ_q) - CNT_W'(1)); // R8
  AST_OCC_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i == dec_i) |=> $stable(occ_q)); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec_i |-> occ_q != '0); // R8
endmodule

// File: rtl/tx_credit_arb.sv
module tx_credit_arb
  import txa_pkg::*;
#(
  parameter int NREQ       = 4,
  parameter int LEN_W      = 4,
  parameter int BASE_DEPTH = 8,
  parameter int WM_W       = 6,
  localparam int IDX_W     = (NREQ > 1) ? $clog2(NREQ) : 1,
  localparam int CNT_W     = $clog2(BASE_DEPTH * 4) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            mode_i,
  input  logic [NPRI*WM_W-1:0]  wm_i,
  input  logic [NREQ-1:0]       req_vld_i,
  input  logic [NREQ*PRI_W-1:0] req_pri_i,
  input  logic [NREQ*LEN_W-1:0] req_len_i,
  input  logic                  beat_rdy_i,
  input  logic                  rel_i,
  output logic [NREQ-1:0]       gnt_o,
  output logic [IDX_W-1:0]      gnt_idx_o,
  output logic                  beat_last_o,
  output logic [CNT_W-1:0]      occ_o
);
  logic [PRI_W-1:0] pri_a [NREQ];
  logic [LEN_W-1:0] len_a [NREQ];
  logic [NREQ-1:0]  elig;
  logic [NPRI-1:0]  credit;
  logic [CNT_W-1:0] depth;
  logic [CNT_W-1:0] occ;
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] sel_q, sel_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             start, last, ctl_en;

  for (genvar i = 0; i < NREQ; i++) begin : g_req
    assign pri_a[i] = req_pri_i[i*PRI_W +: PRI_W];
    assign len_a[i] = req_len_i[i*LEN_W +: LEN_W];
    assign elig[i]  = req_vld_i[i] & credit[pri_a[i]];
    assign gnt_o[i] = busy_q && (sel_q == IDX_W'(i));
  end

  txa_credit #(
    .BASE_DEPTH(BASE_DEPTH),
    .WM_W      (WM_W),
    .CNT_W     (CNT_W)
  ) i_credit (
    .mode_i  (mode_i),
    .wm_i    (wm_i),
    .occ_i   (occ),
    .depth_o (depth),
    .credit_o(credit)
  );

  txa_picker #(
    .NREQ (NREQ),
    .IDX_W(IDX_W)
  ) i_picker (
    .clk       (clk),
    .rst_n     (rst_n),
    .elig_i    (elig),
    .pri_i     (req_pri_i),
    .ptr_i     (ptr_q),
    .pick_vld_o(pick_vld),
    .pick_idx_o(pick_idx)
  );

  txa_occupancy #(
    .CNT_W(CNT_W)
  ) i_occ (
    .clk  (clk),
    .rst_n(rst_n),
    .inc_i(start),
    .dec_i(rel_i),
    .occ_o(occ)
  );

  assign start  = !busy_q && pick_vld;
  assign last   = busy_q && beat_rdy_i && (beat_q == len_q);
  assign ctl_en = start || (busy_q && beat_rdy_i);

  // Grant control next state
  always_comb begin
    busy_d = busy_q;
    sel_d  = sel_q;
    len_d  = len_q;
    beat_d = beat_q;
    ptr_d  = ptr_q;
    if (start) begin
      busy_d = 1'b1;
      sel_d  = pick_idx;
      len_d  = len_a[pick_idx];
      beat_d = '0;
    end else if (busy_q && beat_rdy_i) begin
      if (beat_q == len_q) begin
        busy_d = 1'b0;
        ptr_d  = (sel_q == IDX_W'(NREQ - 1)) ? '0 : sel_q + 1'b1;
      end else begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sel_q  <= '0;
      len_q  <= '0;
      beat_q <= '0;
      ptr_q  <= '0;
    end else if (ctl_en) begin
      busy_q <= busy_d;
      sel_q  <= sel_d;
      len_q  <= len_d;
      beat_q <= beat_d;
      ptr_q  <= ptr_d;
    end
  end

  assign gnt_idx_o   = sel_q;
  assign beat_last_o = last;
  assign occ_o       = occ;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o)); // R7
  AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last) |=> busy_q && $stable(sel_q)); // R7
  AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> gnt_o == '0); // R9
  AST_GNT_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> credit[pri_a[pick_idx]]); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= depth); // R3
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> ptr_q == (($past(sel_q) == IDX_W'(NREQ - 1)) ? '0 : $past(sel_q) + 1'b1)); // R6
endmodule

// File: tb/test_tx_credit_arb.sv
`timescale 1ns/1ps
module test_tx_credit_arb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_i;
  logic [23:0] wm_i;
  logic [3:0]  req_vld_i;
  logic [7:0]  req_pri_i;
  logic [15:0] req_len_i;
  logic        beat_rdy_i;
  logic        rel_i;
  logic [3:0]  gnt_o;
  logic [1:0]  gnt_idx_o;
  logic        beat_last_o;
  logic [5:0]  occ_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  tx_credit_arb i_tx_credit_arb (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wm_i(wm_i),
    .req_vld_i(req_vld_i), .req_pri_i(req_pri_i), .req_len_i(req_len_i),
    .beat_rdy_i(beat_rdy_i), .rel_i(rel_i), .gnt_o(gnt_o),
    .gnt_idx_o(gnt_idx_o), .beat_last_o(beat_last_o), .occ_o(occ_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_depth(input int m);
    return (m == 0) ? 8 : (m == 1) ? 16 : 32;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; req_vld_i = '0; beat_rdy_i = 1'b1; rel_i = 1'b0;
    req_len_i = '0; req_pri_i = '0; wm_i = '0; mode_i = 2'd2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Waits for the next visible grant, returns its index or -1
  task automatic next_grant(output int idx);
    idx = -1;
    for (int t = 0; t < 50; t++) begin
      @(negedge clk);
      if (gnt_o != 4'b0) begin
        idx = int'(gnt_idx_o);
        return;
      end
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int g;
    do_reset();
    // R1: reset state
    check(gnt_o == 4'b0, "R1 gnt", int'(gnt_o), 0);
    check(occ_o == 6'd0, "R1 occ", int'(occ_o), 0);

    // R2/R3: sweep mode and watermark, count grants until credit runs out
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 34; w++) begin
        int d, e;
        d = exp_depth(m);
        e = (w >= d) ? 0 : d - w;
        @(negedge clk);
        mode_i = 2'(m);
        wm_i = {4{6'(w)}};
        req_pri_i = 8'b0; req_len_i = 16'b0; beat_rdy_i = 1'b1;
        req_vld_i = 4'b0001;
        repeat (2 * d + 6) @(negedge clk);
        req_vld_i = 4'b0;
        repeat (3) @(negedge clk);
        check(int'(occ_o) == e, $sformatf("R2 R3 mode%0d wm%0d", m, w), int'(occ_o), e);
        if (e > 0) begin
          rel_i = 1'b1;
          repeat (e) @(negedge clk);
          rel_i = 1'b0;
        end
        @(negedge clk);
        check(occ_o == 6'd0, "R8 drained", int'(occ_o), 0);
      end
    end

    // R1/R6: all four at one priority, rotation from requester 0
    do_reset();
    req_pri_i = {4{2'd2}}; req_vld_i = 4'b1111;
    for (int k = 0; k < 8; k++) begin
      next_grant(g);
      check(g == k % 4, "R6 R1 rotation", g, k % 4);
    end
    req_vld_i = 4'b0;

    // R6: only requesters 1 and 3 contend
    do_reset();
    req_pri_i = 8'b0; req_vld_i = 4'b1010;
    for (int k = 0; k < 4; k++) begin
      next_grant(g);
      check(g == ((k % 2 == 0) ? 1 : 3), "R6 pair", g, (k % 2 == 0) ? 1 : 3);
    end
    req_vld_i = 4'b0;

    // R5: strict priority, requester 2 at 3, 3 at 2, 0 at 1
    do_reset();
    req_pri_i = {2'd2, 2'd3, 2'd0, 2'd1}; req_vld_i = 4'b1101;
    next_grant(g); check(g == 2, "R5 top", g, 2);
    req_vld_i[2] = 1'b0;
    next_grant(g); check(g == 3, "R5 second", g, 3);
    req_vld_i[3] = 1'b0;
    next_grant(g); check(g == 0, "R5 third", g, 0);
    req_vld_i = 4'b0;

    // R4: priority 3 has no credit, priority 1 does
    do_reset();
    wm_i = {6'd40, 6'd0, 6'd0, 6'd0};
    req_pri_i = {2'd0, 2'd0, 2'd1, 2'd3}; req_vld_i = 4'b0011;
    next_grant(g); check(g == 1, "R4 excluded", g, 1);
    next_grant(g); check(g == 1, "R4 still excluded", g, 1);
    req_vld_i = 4'b0;

    // R7/R9: 4-beat packet with stalls, late higher-priority arrival
    do_reset();
    beat_rdy_i = 1'b0;
    req_pri_i = {2'd0, 2'd3, 2'd0, 2'd1}; req_len_i = 16'h0003;
    req_vld_i = 4'b0001;
    @(negedge clk);
    check(gnt_o == 4'b0001, "R9 grant visible", int'(gnt_o), 1);
    check(occ_o == 6'd1, "R8 grant inc", int'(occ_o), 1);
    req_vld_i = 4'b0101;
    begin
      bit pat [6] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      int acc = 0;
      for (int s = 0; s < 6; s++) begin
        check(gnt_o == 4'b0001, "R7 held", int'(gnt_o), 1);
        beat_rdy_i = pat[s];
        if (pat[s]) acc++;
        #1;
        check(beat_last_o == (pat[s] && acc == 4), "R7 last", int'(beat_last_o),
              int'(pat[s] && acc == 4));
        @(negedge clk);
      end
    end
    req_vld_i = 4'b0100;
    check(gnt_o == 4'b0, "R9 gap", int'(gnt_o), 0);
    @(negedge clk);
    check(gnt_o == 4'b0100, "R9 next grant", int'(gnt_o), 4);
    req_vld_i = 4'b0; beat_rdy_i = 1'b1;
    repeat (2) @(negedge clk);
    check(occ_o == 6'd2, "R8 two grants", int'(occ_o), 2);

    // R8: release and grant in the same cycle
    rel_i = 1'b1; req_len_i = 16'b0; req_vld_i = 4'b0001;
    @(negedge clk);
    rel_i = 1'b0; req_vld_i = 4'b0;
    check(gnt_o == 4'b0001, "R8 grant seen", int'(gnt_o), 1);
    check(occ_o == 6'd2, "R8 balanced", int'(occ_o), 2);
    rel_i = 1'b1;
    @(negedge clk);
    rel_i = 1'b0;
    check(occ_o == 6'd1, "R8 release", int'(occ_o), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule